// File: doc/BRIEF.md
# Time-of-Day Counter with 12/24-Hour Display

This block keeps the time of day as seconds, minutes and hours. It runs entirely from one system clock and counts when a single-cycle one-second tick arrives. Seconds and minutes are held as two-digit BCD values. The hour is held internally as a binary count from 0 to 23. A format stage turns that count into two BCD digits, in either 24-hour or 12-hour form, depending on a mode input. Because the stored value never changes with the mode, flipping the mode changes only how the current hour is shown.

A set/run selector supports adjusting the time. In set mode, the minute key and the hour key each step their own field by one on every rising edge. The carries that the seconds and minutes would normally pass upward are ignored. Seconds keep running on the tick in both modes. A synchronous clear and a count enable control the whole chain. A flag that is high while the minutes read 59 is provided for downstream logic that acts at the top of the hour.

Top module: `tod_counter`

## Requirements
- R1: On each cycle with `tick` and `count_en` high, seconds advance by one in BCD (ones 0–9, tens 0–5). After 59 they return to 00, and that wrap produces a carry into the minutes.
- R2: In run mode (`set_mode` low), minutes advance by one on each seconds carry and cycle 00–59. When minutes wrap from 59 to 00 on a carry, the hour advances by one.
- R3: With `mode24` high, the hour digits show the internal hour 0–23 as 00–23. After 23 the display returns to 00.
- R4: With `mode24` low, internal hour 0 shows as 12, hours 1–12 show unchanged, and hours 13–23 show as 01–11. The display never reads 00, and a change of `mode24` takes effect on the outputs in the same cycle.
- R5: In set mode, each rising edge on `key_min` advances minutes by one, wrapping 59 to 00 without touching the hour. Each rising edge on `key_hour` advances the hour by one, modulo 24.
- R6: In set mode, a seconds wrap does not advance the minutes. Seconds still count on `tick`.
- R7: Keys are edge-detected, so a key held high for many cycles gives exactly one step. In run mode, key activity has no effect on minutes or hours.
- R8: When `clear` is high at a clock edge, seconds, minutes and the internal hour become zero at that edge. This takes priority over tick, keys and enable.
- R9: With `count_en` low, neither ticks nor key edges change any field.
- R10: `minute59` is high exactly while the minute digits read 5 and 9.
- R11: While `rst_n` is low, all fields are zero, so the display shows 00:00:00 in 24-hour mode and 12:00:00 in 12-hour mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse marking a second |
| count_en | input | 1 | High to allow any field to advance |
| clear | input | 1 | Synchronous clear of all fields |
| mode24 | input | 1 | High: 24-hour display, low: 12-hour display |
| set_mode | input | 1 | High: keys adjust minutes and hours, carries ignored |
| key_min | input | 1 | Minute adjust key, rising-edge active |
| key_hour | input | 1 | Hour adjust key, rising-edge active |
| sec_ones | output | 4 | Seconds units digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| min_ones | output | 4 | Minutes units digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| hr_ones | output | 4 | Hours units digit, BCD, formatted per mode |
| hr_tens | output | 4 | Hours tens digit, BCD, formatted per mode |
| minute59 | output | 1 | High while minutes read 59 |

## Verification
The hardest case to reach from the ports is the full-day rollover. It needs 23:59:59 followed by a tick, in both display modes, and in 12-hour mode the 11→12 and 12→01 changes must also be seen. The stimulus first uses set mode to place the hour and minutes with key presses, and lets ticks bring the seconds to 55. It then switches to run mode and ticks through the boundary. The hour format is covered exhaustively: the hour key steps through all 24 internal hours, and each one is read in both modes.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int DIGIT_W   = 4;
    localparam int DIGIT_TOP = 9;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        digit_t tens;
        digit_t ones;
    } bcd2_t;
endpackage

// File: rtl/tod_key_edge.sv
module tod_key_edge #(
    parameter int N_KEYS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_KEYS-1:0] keys,
    output logic [N_KEYS-1:0] rise
);
    typedef struct packed {
        logic [N_KEYS-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d.prev = keys;
    end

    // A key counts only in the cycle it is first seen high.
    assign rise = keys & ~st_q.prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tod_bcd_counter.sv
module tod_bcd_counter
    import tod_pkg::*;
#(
    parameter int TENS_MAX = 5
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  inc,
    output bcd2_t value,
    output logic  at_max
);
    localparam digit_t TENS_LAST = digit_t'(TENS_MAX);
    localparam digit_t ONES_LAST = digit_t'(DIGIT_TOP);

    bcd2_t st_d, st_q;

    assign at_max = (st_q.tens == TENS_LAST) && (st_q.ones == ONES_LAST);

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (inc) begin
            if (at_max) begin
                st_d = '0;
            end else if (st_q.ones == ONES_LAST) begin
                st_d.ones = '0;
                st_d.tens = st_q.tens + digit_t'(1);
            end else begin
                st_d.ones = st_q.ones + digit_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q;
endmodule

// File: rtl/tod_hour_counter.sv
module tod_hour_counter #(
    parameter int HOURS  = 24,
    parameter int HOUR_W = $clog2(HOURS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              inc,
    output logic [HOUR_W-1:0] hour
);
    localparam logic [HOUR_W-1:0] LAST = HOUR_W'(HOURS - 1);

    typedef struct packed {
        logic [HOUR_W-1:0] count;
    } hour_st_t;

    hour_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.count = '0;
        end else if (inc) begin
            st_d.count = (st_q.count == LAST) ? '0 : st_q.count + HOUR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hour = st_q.count;
endmodule

// File: rtl/tod_hour_fmt.sv
module tod_hour_fmt
    import tod_pkg::*;
#(
    parameter int HOURS  = 24,
    parameter int HOUR_W = $clog2(HOURS)
) (
    input  logic [HOUR_W-1:0] hour,
    input  logic              mode24,
    output bcd2_t             shown
);
    localparam int HALF = HOURS / 2;

    int hv;
    int dv;

    always_comb begin
        hv = int'(hour);
        if (mode24)          dv = hv;
        else if (hv == 0)    dv = HALF;
        else if (hv > HALF)  dv = hv - HALF;
        else                 dv = hv;
        shown.tens = digit_t'(dv / 10);
        shown.ones = digit_t'(dv % 10);
    end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int HOURS  = 24,
    parameter int MS_TOP = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         count_en,
    input  logic         clear,
    input  logic         mode24,
    input  logic         set_mode,
    input  logic         key_min,
    input  logic         key_hour,
    output logic [3:0]   sec_ones,
    output logic [3:0]   sec_tens,
    output logic [3:0]   min_ones,
    output logic [3:0]   min_tens,
    output logic [3:0]   hr_ones,
    output logic [3:0]   hr_tens,
    output logic         minute59
);
    localparam int HOUR_W = $clog2(HOURS);
    localparam int KEY_MIN_IDX  = 0;
    localparam int KEY_HOUR_IDX = 1;

    typedef struct packed {
        logic sec_inc;
        logic min_inc;
        logic hr_inc;
    } step_t;

    logic [1:0]        key_rise;
    bcd2_t             sec_v, min_v, hr_v;
    logic              sec_max, min_max;
    logic [HOUR_W-1:0] hour_bin;
    step_t             step_d;

    tod_key_edge #(.N_KEYS(2)) i_keys (
        .clk   (clk),
        .rst_n (rst_n),
        .keys  ({key_hour, key_min}),
        .rise  (key_rise)
    );

    always_comb begin
        logic adv;
        logic sec_wrap;
        adv              = count_en && !clear;
        step_d.sec_inc   = adv && tick;
        sec_wrap         = step_d.sec_inc && sec_max;
        step_d.min_inc   = adv && (set_mode ? key_rise[KEY_MIN_IDX] : sec_wrap);
        step_d.hr_inc    = adv && (set_mode ? key_rise[KEY_HOUR_IDX]
                                            : (sec_wrap && min_max));
    end

    tod_bcd_counter #(.TENS_MAX(MS_TOP)) i_sec (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .inc    (step_d.sec_inc),
        .value  (sec_v),
        .at_max (sec_max)
    );

    tod_bcd_counter #(.TENS_MAX(MS_TOP)) i_min (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .inc    (step_d.min_inc),
        .value  (min_v),
        .at_max (min_max)
    );

    tod_hour_counter #(.HOURS(HOURS), .HOUR_W(HOUR_W)) i_hour (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .inc   (step_d.hr_inc),
        .hour  (hour_bin)
    );

    tod_hour_fmt #(.HOURS(HOURS), .HOUR_W(HOUR_W)) i_fmt (
        .hour   (hour_bin),
        .mode24 (mode24),
        .shown  (hr_v)
    );

    assign sec_ones = sec_v.ones;
    assign sec_tens = sec_v.tens;
    assign min_ones = min_v.ones;
    assign min_tens = min_v.tens;
    assign hr_ones  = hr_v.ones;
    assign hr_tens  = hr_v.tens;
    assign minute59 = min_max;
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       count_en,
    input logic       clear,
    input logic       mode24,
    input logic       set_mode,
    input logic       key_min,
    input logic       key_hour,
    input logic [3:0] sec_ones,
    input logic [3:0] sec_tens,
    input logic [3:0] min_ones,
    input logic [3:0] min_tens,
    input logic [3:0] hr_ones,
    input logic [3:0] hr_tens,
    input logic       minute59
);
    p_sec_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_ones <= 4'd9) && (sec_tens <= 4'd5));

    p_sec_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick && count_en) && !clear) |=> $stable({sec_tens, sec_ones}));

    p_hour24_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode24 |-> ((hr_tens < 4'd2 && hr_ones <= 4'd9) ||
                    (hr_tens == 4'd2 && hr_ones <= 4'd3)));

    p_hour12_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode24 |-> ((hr_tens == 4'd0 && hr_ones != 4'd0 && hr_ones <= 4'd9) ||
                     (hr_tens == 4'd1 && hr_ones <= 4'd2)));

    p_run_keys_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_mode && !(tick && count_en) && !clear) |=> $stable({min_tens, min_ones}));

    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> ({sec_tens, sec_ones, min_tens, min_ones} == 16'h0000));

    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !clear) |=> $stable({sec_tens, sec_ones, min_tens, min_ones}));

    p_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        minute59 == (min_tens == 4'd5 && min_ones == 4'd9));
endmodule

bind tod_counter tod_counter_chk i_chk (.*);

// File: tb/test_tod_counter.sv
module test_tod_counter;
    logic       clk = 1'b0;
    logic       rst_n, tick, count_en, clear, mode24, set_mode, key_min, key_hour;
    logic [3:0] sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens;
    logic       minute59;

    always #10 clk = ~clk;

    tod_counter i_tod_counter (.*);

    int  s_m, m_m, h_m;
    bit  km_prev, kh_prev;
    int  n_vec, n_bad;
    bit  done;

    function automatic int shown_hour(int h, bit m24);
        if (m24)     return h;
        if (h == 0)  return 12;
        if (h > 12)  return h - 12;
        return h;
    endfunction

    task automatic compare(string tag);
        int eh;
        eh = shown_hour(h_m, mode24);
        n_vec++;
        if (sec_ones != 4'(s_m % 10) || sec_tens != 4'(s_m / 10) ||
            min_ones != 4'(m_m % 10) || min_tens != 4'(m_m / 10) ||
            hr_ones  != 4'(eh % 10)  || hr_tens  != 4'(eh / 10)) begin
            n_bad++;
            $display("FAIL %s: got %0d%0d:%0d%0d:%0d%0d exp %02d:%02d:%02d",
                     tag, hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones,
                     eh, m_m, s_m);
        end
        // flag check, R10
        n_vec++;
        if (minute59 !== (m_m == 59)) begin
            n_bad++;
            $display("FAIL R10: minute59 got %0b exp %0b", minute59, (m_m == 59));
        end
    endtask

    task automatic cyc(bit t, bit km, bit kh, string tag);
        bit mp, hp, sw, mw;
        @(negedge clk);
        tick = t; key_min = km; key_hour = kh;
        mp = km && !km_prev; hp = kh && !kh_prev;
        km_prev = km; kh_prev = kh;
        if (clear) begin
            s_m = 0; m_m = 0; h_m = 0;
        end else if (count_en) begin
            sw = t && (s_m == 59);
            if (t) s_m = (s_m + 1) % 60;
            if (set_mode) begin
                if (mp) m_m = (m_m + 1) % 60;
                if (hp) h_m = (h_m + 1) % 24;
            end else if (sw) begin
                mw  = (m_m == 59);
                m_m = (m_m + 1) % 60;
                if (mw) h_m = (h_m + 1) % 24;
            end
        end
        @(posedge clk);
        #5;
        compare(tag);
    endtask

    task automatic press_min(string tag);
        cyc(0, 1, 0, tag);
        cyc(0, 0, 0, tag);
    endtask

    task automatic press_hour(string tag);
        cyc(0, 0, 1, tag);
        cyc(0, 0, 0, tag);
    endtask

    initial begin
        #(20 * 190000);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; tick = 0; count_en = 1; clear = 0; mode24 = 1;
        set_mode = 0; key_min = 0; key_hour = 0;
        s_m = 0; m_m = 0; h_m = 0;
        #35;
        compare("R11 reset 24h");
        mode24 = 0; #1;
        compare("R11 R4 reset 12h");
        mode24 = 1;
        @(negedge clk); rst_n = 1;

        // R1 R2: run a bit over an hour in 24-hour mode
        for (int i = 0; i < 3700; i++) cyc(1, 0, 0, "R1 R2 run24");

        // R5 R3 R4: step the hour key through every internal hour, read both formats
        set_mode = 1;
        for (int i = 0; i < 24; i++) begin
            press_hour("R5 hour key");
            mode24 = 0; #1; compare("R4 hour fmt 12h");
            mode24 = 1; #1; compare("R3 hour fmt 24h");
        end

        // R5: minute key wraps 59 -> 00 without touching hour
        for (int i = 0; i < 3; i++) press_hour("R5 preset");
        for (int i = 0; i < 61; i++) press_min("R5 minute wrap");

        // R6: seconds run in set mode, their wrap does not reach minutes
        for (int i = 0; i < 130; i++) cyc(1, 0, 0, "R6 set carry ignored");

        // R7: held key gives one step
        for (int i = 0; i < 8; i++) cyc(0, 1, 0, "R7 held min key");
        cyc(0, 0, 0, "R7 release");
        for (int i = 0; i < 8; i++) cyc(0, 0, 1, "R7 held hour key");
        cyc(0, 0, 0, "R7 release");

        // R7: keys ignored in run mode
        set_mode = 0;
        for (int i = 0; i < 5; i++) begin
            press_min("R7 run min key");
            press_hour("R7 run hour key");
        end

        // R9: disabled, nothing moves
        count_en = 0;
        for (int i = 0; i < 70; i++) cyc(1, 0, 0, "R9 ticks frozen");
        set_mode = 1;
        for (int i = 0; i < 4; i++) begin
            press_min("R9 min key frozen");
            press_hour("R9 hour key frozen");
        end
        count_en = 1;

        // R8: clear beats tick and key
        clear = 1;
        cyc(1, 1, 1, "R8 clear");
        clear = 0;
        cyc(0, 0, 0, "R8 after clear");
        mode24 = 0; #1; compare("R8 R4 clear shows 12");
        mode24 = 1;

        // R3: day rollover in 24-hour mode
        for (int i = 0; i < 23; i++) press_hour("R3 preset");
        for (int i = 0; i < 59; i++) press_min("R3 preset");
        while (s_m != 55) cyc(1, 0, 0, "R6 preset seconds");
        set_mode = 0;
        for (int i = 0; i < 10; i++) cyc(1, 0, 0, "R3 day rollover");

        // R4: day rollover and 11/12/01 transitions in 12-hour mode
        mode24 = 0;
        set_mode = 1;
        for (int i = 0; i < 23; i++) press_hour("R4 preset");
        for (int i = 0; i < 59; i++) press_min("R4 preset");
        while (s_m != 55) cyc(1, 0, 0, "R6 preset seconds");
        set_mode = 0;
        for (int i = 0; i < 10; i++) cyc(1, 0, 0, "R4 day rollover");

        clear = 1; cyc(0, 0, 0, "R8 clear"); clear = 0;
        for (int i = 0; i < 11; i++) begin
            for (int j = 0; j < 3600; j++) cyc(1, 0, 0, "R4 R2 run12");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule